// File: doc/BRIEF.md
# Serial SAR Converter Output Frame Logic

This block is the digital side of a small serial successive-approximation converter. A host holds an active-low chip select and toggles a serial clock; the block latches a parallel result from the converter core when chip select falls. It then shifts out a fixed 16-bit frame: two zero bits, the result MSB first, and zero padding to the end. The result width is a parameter, 10 bits by default or 8 bits as a variant. The serial output has an enable, so a pad can tri-state it.

The block also tracks the phase of each frame. A frame is in conversion until the serial clock rises after enough falling edges, and in acquisition after that. The number of falling edges seen when chip select rises early decides what happens: an early rise aborts the conversion, and a rise inside a middle window powers the block down. A long dummy frame wakes it up again. A data-valid flag, updated at the start of each frame, marks frames whose data cannot be trusted. All inputs are sampled on a fast system clock, and edges of chip select and the serial clock are found by comparing each sample with the one before it.

Top module: `serial_adc_frame`

## Requirements
- R1: After reset, sdo_oe_o is 0, phase_o is 0 (idle), and valid_o is 1. The phase codes are 0 idle, 1 converting, 2 acquiring and 3 powered down.
- R2: A falling edge of cs_ni latches sample_i, clears the falling-edge count, and sets phase_o to 1 unless the block is powered down. In the next cycle it drives sdo_oe_o=1 with sdo_o=0, which is the first leading zero.
- R3: After the k-th counted falling edge of sclk_i (k=1..15), sdo_o carries frame bit k. Bits 0 and 1 are 0, bits 2..RES_W+1 are the latched sample MSB first, and the remaining bits are 0. Changes to sample_i after the chip-select fall have no effect on the frame.
- R4: sdo_oe_o drops to 0 after the 16th counted falling edge, and it is 0 in every cycle after chip select has been sampled high.
- R5: In phase 1, the first rising edge of sclk_i seen after at least RES_W+1 counted falling edges moves phase_o to 2. Phase 2 holds until the next chip-select fall.
- R6: If chip select rises in phase 1 with a count from 2 to 9 and no conversion end in that cycle, phase_o becomes 3 (powered down).
- R7: If chip select rises in phase 1 with any other count and no conversion end, phase_o becomes 0 and the next frame is invalid.
- R8: In phase 3, a chip-select fall does not start a conversion. Falling edges are still counted. The 11th counted falling edge of a frame moves phase_o to 2, and the next frame is invalid.
- R9: valid_o changes only on a chip-select fall. It becomes 0 if the block is powered down or if the previous frame was aborted or woke the block. Otherwise it becomes 1.
- R10: A sclk_i fall in the same cycle as a cs_ni fall is not counted. A conversion-ending sclk_i rise in the same cycle as a cs_ni rise counts as a normal end, so phase_o becomes 2.
- R11: The falling-edge count saturates at 16. Further falling edges in the same frame keep sdo_oe_o at 0 and sdo_o at 0.
- R12: With RES_W=8, the frame carries 6 trailing zeros and the conversion ends after the 9th falling edge. A chip-select rise after 10 falling edges therefore leaves phase 2 in place, where the 10-bit block goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select from the host |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| sample_i | input | RES_W | Parallel result from the converter core |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| phase_o | output | 2 | Current phase: 0 idle, 1 converting, 2 acquiring, 3 powered down |
| valid_o | output | 1 | High when the current frame carries valid data |

## Verification
Chip-select edges and serial-clock edges can land in the same system-clock cycle, and the block must rank them. The bench lines up a chip-select fall with a serial-clock fall, then shows that the edge was not counted: with an all-ones sample, a zero still appears after the next fall. It also raises chip select in the same cycle as the serial-clock rise that ends the conversion, and expects acquisition rather than an abort. Both cases are judged against a behavioural model that runs beside a 10-bit and an 8-bit instance, so one stimulus exposes the different conversion windows of the two widths.

// File: rtl/serial_adc_frame_pkg.sv
`timescale 1ns/1ps
package serial_adc_frame_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_ACQ  = 2'd2,
    PH_PDN  = 2'd3
  } phase_e;
endpackage

// File: rtl/saf_edge_det.sv
`timescale 1ns/1ps
module saf_edge_det #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o,
  output logic rise_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end

  assign fall_o = q_o & ~d_i;
  assign rise_o = ~q_o & d_i;
endmodule

// File: rtl/saf_edge_cnt.sv
`timescale 1ns/1ps
module saf_edge_cnt #(
  parameter int MAX = 16,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX_C = W'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && cnt_o != MAX_C) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/saf_shifter.sv
`timescale 1ns/1ps
module saf_shifter #(
  parameter int RES_W     = 10,
  parameter int FRAME_LEN = 16,
  parameter int LEAD_Z    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             cs_low_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  localparam int TRAIL_Z = FRAME_LEN - LEAD_Z - RES_W;

  logic [FRAME_LEN-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= FRAME_LEN'(sample_i) << TRAIL_Z;
    else if (shift_i) sh_q <= sh_q << 1;
  end

  assign sdo_oe_o = cs_low_i & ~done_i;
  assign sdo_o    = sdo_oe_o & sh_q[FRAME_LEN-1];
endmodule

// File: rtl/saf_phase_ctrl.sv
`timescale 1ns/1ps
module saf_phase_ctrl
  import serial_adc_frame_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int CNT_W  = 5,
  parameter int PD_LO  = 2,
  parameter int PD_HI  = 10,
  parameter int WAKE_N = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_rise_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] cnt_i,
  output phase_e           phase_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] DONE_C   = CNT_W'(RES_W + 1);
  localparam logic [CNT_W-1:0] PD_LO_C  = CNT_W'(PD_LO);
  localparam logic [CNT_W-1:0] PD_HI_C  = CNT_W'(PD_HI);
  localparam logic [CNT_W-1:0] WAKE_M1C = CNT_W'(WAKE_N - 1);

  logic bad_q;
  logic conv_done, in_pd_win;

  assign conv_done = sclk_rise_i & (cnt_i >= DONE_C);
  assign in_pd_win = (cnt_i >= PD_LO_C) & (cnt_i < PD_HI_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_IDLE;
      valid_o <= 1'b1;
      bad_q   <= 1'b0;
    end else if (cs_fall_i) begin
      valid_o <= ~bad_q & (phase_o != PH_PDN);
      bad_q   <= 1'b0;
      if (phase_o != PH_PDN) phase_o <= PH_CONV;
    end else begin
      unique case (phase_o)
        PH_CONV: begin
          // a finishing clock edge outranks a simultaneous deselect
          if (conv_done) phase_o <= PH_ACQ;
          else if (cs_rise_i) begin
            phase_o <= in_pd_win ? PH_PDN : PH_IDLE;
            bad_q   <= 1'b1;
          end
        end
        PH_PDN: begin
          if (inc_i && cnt_i == WAKE_M1C) begin
            phase_o <= PH_ACQ;
            bad_q   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_adc_frame.sv
`timescale 1ns/1ps
module serial_adc_frame
  import serial_adc_frame_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int FRAME_LEN = 16,
  parameter int LEAD_Z    = 2,
  parameter int PD_LO     = 2,
  parameter int PD_HI     = 10,
  parameter int WAKE_N    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [1:0]       phase_o,
  output logic             valid_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_LEN);

  // index 0: chip select, index 1: serial clock; both idle high
  logic [1:0] pin_w, q_w, fall_w, rise_w;
  assign pin_w = {sclk_i, cs_ni};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    saf_edge_det #(.RST_VAL(1'b1)) i_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_w[g]),
      .q_o    (q_w[g]),
      .fall_o (fall_w[g]),
      .rise_o (rise_w[g])
    );
  end

  logic cs_fall, cs_rise, sclk_rise, inc;
  logic [CNT_W-1:0] cnt_q;
  phase_e phase;

  assign cs_fall   = fall_w[0];
  assign cs_rise   = rise_w[0];
  assign sclk_rise = rise_w[1];
  assign inc       = fall_w[1] & ~cs_ni & ~cs_fall;

  saf_edge_cnt #(.MAX(FRAME_LEN), .W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cs_fall),
    .inc_i  (inc),
    .cnt_o  (cnt_q)
  );

  saf_shifter #(.RES_W(RES_W), .FRAME_LEN(FRAME_LEN), .LEAD_Z(LEAD_Z)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cs_fall),
    .shift_i  (inc),
    .cs_low_i (~q_w[0]),
    .done_i   (cnt_q >= FRAME_C),
    .sample_i (sample_i),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  saf_phase_ctrl #(
    .RES_W(RES_W), .CNT_W(CNT_W), .PD_LO(PD_LO), .PD_HI(PD_HI), .WAKE_N(WAKE_N)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .sclk_rise_i (sclk_rise),
    .inc_i       (inc),
    .cnt_i       (cnt_q),
    .phase_o     (phase),
    .valid_o     (valid_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/serial_adc_frame_chk.sv
`timescale 1ns/1ps
module serial_adc_frame_chk #(
  parameter int RES_W     = 10,
  parameter int FRAME_LEN = 16,
  parameter int WAKE_N    = 11,
  parameter int CNT_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic [1:0]       phase_o,
  input logic             valid_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cs_fall
);
  localparam logic [CNT_W-1:0] DONE_C  = CNT_W'(RES_W + 1);
  localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] WAKE_C  = CNT_W'(WAKE_N);

  // R2
  cs_fall_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_ni) |=> (sdo_oe_o && !sdo_o));

  // R4
  cs_high_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !sdo_oe_o);

  // R5
  conv_end_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && $past(phase_o) == 2'd1) |-> $past(cnt_q) >= DONE_C);

  // R6
  pd_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd3 && $past(phase_o) != 2'd3) |-> ($past(phase_o) == 2'd1 && $past(cs_ni)));

  // R8
  pd_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_o) == 2'd3 && phase_o != 2'd3) |-> (phase_o == 2'd2 && cnt_q == WAKE_C));

  // R9
  valid_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(valid_o) |-> $past(cs_fall));

  // R11
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FRAME_C);
endmodule

bind serial_adc_frame serial_adc_frame_chk #(
  .RES_W(RES_W), .FRAME_LEN(FRAME_LEN), .WAKE_N(WAKE_N), .CNT_W(CNT_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o),
  .phase_o  (phase_o),
  .valid_o  (valid_o),
  .cnt_q    (cnt_q),
  .cs_fall  (cs_fall)
);

// File: tb/test_serial_adc_frame.sv
`timescale 1ns/1ps
module test_serial_adc_frame;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1;
  logic sclk = 1'b1;
  logic [9:0] smp = '0;

  logic sdo10, oe10, v10, sdo8, oe8, v8;
  logic [1:0] ph10, ph8;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  serial_adc_frame i_serial_adc_frame (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs), .sclk_i(sclk), .sample_i(smp),
    .sdo_o(sdo10), .sdo_oe_o(oe10), .phase_o(ph10), .valid_o(v10)
  );

  serial_adc_frame #(.RES_W(8)) i_serial_adc_frame_b8 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs), .sclk_i(sclk), .sample_i(smp[9:2]),
    .sdo_o(sdo8), .sdo_oe_o(oe8), .phase_o(ph8), .valid_o(v8)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: index 0 is the 10-bit instance, index 1 the 8-bit one
  int  m_res [2] = '{10, 8};
  int  m_cnt [2];
  int  m_ph  [2];
  int  m_word[2];
  bit  m_bad [2];
  bit  m_val [2];
  bit  m_csq, m_sclkq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_csq = 1; m_sclkq = 1;
      for (int r = 0; r < 2; r++) begin
        m_cnt[r] = 0; m_ph[r] = 0; m_word[r] = 0; m_bad[r] = 0; m_val[r] = 1;
      end
    end else begin
      bit cf, cr, sf, sr;
      cf = m_csq && !cs;
      cr = !m_csq && cs;
      sf = m_sclkq && !sclk;
      sr = !m_sclkq && sclk;
      for (int r = 0; r < 2; r++) begin
        bit inc;
        int s;
        inc = sf && !cs && !cf;
        s = (r == 0) ? int'(smp) : int'(smp[9:2]);
        if (cf) begin
          m_val[r] = !m_bad[r] && m_ph[r] != 3;
          m_bad[r] = 0;
          if (m_ph[r] != 3) m_ph[r] = 1;
          m_word[r] = s << (14 - m_res[r]);
        end else if (m_ph[r] == 1) begin
          if (sr && m_cnt[r] >= m_res[r] + 1) m_ph[r] = 2;
          else if (cr) begin
            m_ph[r] = (m_cnt[r] >= 2 && m_cnt[r] < 10) ? 3 : 0;
            m_bad[r] = 1;
          end
        end else if (m_ph[r] == 3 && inc && m_cnt[r] == 10) begin
          m_ph[r] = 2;
          m_bad[r] = 1;
        end
        if (cf) m_cnt[r] = 0;
        else if (inc && m_cnt[r] < 16) m_cnt[r] = m_cnt[r] + 1;
      end
      m_csq = cs;
      m_sclkq = sclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int r = 0; r < 2; r++) begin
        int eoe, esdo;
        eoe  = (!m_csq && m_cnt[r] < 16) ? 1 : 0;
        esdo = eoe ? ((m_word[r] >> (15 - m_cnt[r])) & 1) : 0;
        chk(cur_req, r ? oe8 : oe10, eoe);
        chk(cur_req, r ? sdo8 : sdo10, esdo);
        chk(cur_req, r ? ph8 : ph10, m_ph[r]);
        chk(cur_req, r ? v8 : v10, m_val[r]);
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // full frame with bit capture; sample_i is flipped mid-frame
  task automatic data_frame(logic [9:0] s, int n, int ev10, int ev8);
    logic [15:0] got10, got8, exp10, exp8;
    got10 = '0; got8 = '0;
    smp = s;
    cs = 0; wait_n(2);
    chk("R2", ph10, 1); chk("R2", oe10, 1); chk("R2", sdo10, 0);
    chk("R9", v10, ev10); chk("R9", v8, ev8);
    got10[15] = sdo10; got8[15] = sdo8;
    for (int k = 1; k <= n; k++) begin
      sclk = 0;
      if (k == 5) smp = ~s;
      wait_n(2);
      if (k < 16) begin got10[15-k] = sdo10; got8[15-k] = sdo8; end
      else begin
        chk(k == 16 ? "R4" : "R11", oe10, 0);
        chk("R11", sdo8, 0);
      end
      sclk = 1; wait_n(2);
    end
    exp10 = {2'b00, s, 4'b0000};
    exp8  = {2'b00, s[9:2], 6'b000000};
    if (n >= 15) begin
      chk("R3", int'(got10), int'(exp10));
      chk("R12", int'(got8), int'(exp8));
    end
    cs = 1; wait_n(2);
    chk("R5", ph10, 2); chk("R5", ph8, 2); chk("R4", oe10, 0);
    wait_n(4);
  endtask

  // n falling edges; end_low leaves out the rise after the last one
  task automatic bare_frame(int n, bit end_low);
    cs = 0; wait_n(2);
    for (int k = 1; k <= n; k++) begin
      sclk = 0; wait_n(2);
      if (!(end_low && k == n)) begin sclk = 1; wait_n(2); end
    end
    cs = 1; wait_n(2);
    sclk = 1; wait_n(4);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    cur_req = "R1";
    chk("R1", oe10, 0); chk("R1", ph10, 0); chk("R1", v10, 1);
    chk("R1", oe8, 0);  chk("R1", ph8, 0);  chk("R1", v8, 1);

    cur_req = "R3";
    data_frame(10'h2AA, 16, 1, 1);
    data_frame(10'h3FF, 16, 1, 1);
    data_frame(10'h155, 16, 1, 1);
    data_frame(10'($urandom), 16, 1, 1);
    cur_req = "R11";
    data_frame(10'h1C7, 19, 1, 1);

    cur_req = "R7";
    bare_frame(1, 0);
    chk("R7", ph10, 0); chk("R7", ph8, 0);
    data_frame(10'h0F0, 16, 0, 0);
    data_frame(10'h30C, 16, 1, 1);

    cur_req = "R12";
    bare_frame(10, 1);
    chk("R7", ph10, 0); chk("R12", ph8, 2);
    data_frame(10'h2D2, 16, 0, 1);

    cur_req = "R6";
    bare_frame(5, 0);
    chk("R6", ph10, 3); chk("R6", ph8, 3); chk("R4", oe10, 0);
    cur_req = "R8";
    bare_frame(8, 0);
    chk("R8", ph10, 3); chk("R8", ph8, 3);
    cs = 0; wait_n(2);
    chk("R8", ph10, 3); chk("R9", v10, 0);
    for (int k = 1; k <= 12; k++) begin
      sclk = 0; wait_n(2);
      if (k == 10) chk("R8", ph10, 3);
      if (k == 11) begin chk("R8", ph10, 2); chk("R8", ph8, 2); end
      sclk = 1; wait_n(2);
    end
    cs = 1; wait_n(4);
    data_frame(10'h11B, 16, 0, 0);
    data_frame(10'h3A5, 16, 1, 1);

    cur_req = "R6";
    bare_frame(2, 0);
    chk("R6", ph10, 3);
    bare_frame(11, 0);
    chk("R8", ph10, 2);
    bare_frame(9, 1);
    chk("R6", ph8, 3); chk("R6", ph10, 3);
    bare_frame(12, 0);
    data_frame(10'h066, 16, 0, 0);

    cur_req = "R10";
    smp = 10'h3FF;
    cs = 0; sclk = 0; wait_n(2);
    chk("R10", ph10, 1); chk("R10", oe10, 1); chk("R10", sdo10, 0);
    sclk = 1; wait_n(2);
    for (int k = 1; k <= 11; k++) begin
      sclk = 0; wait_n(2);
      if (k == 1) chk("R10", sdo10, 0);
      if (k == 2) chk("R10", sdo10, 1);
      if (k < 11) begin sclk = 1; wait_n(2); end
    end
    cs = 1; sclk = 1; wait_n(2);
    chk("R10", ph10, 2); chk("R10", ph8, 2);
    wait_n(4);
    data_frame(10'h24E, 16, 1, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule